// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation table held in memory. A root frame number names the physical page that holds the top-level directory. The walker reads one directory entry. That entry names the frame of a second-level table, and the walker then reads one entry from that table. The second entry names the physical page frame. The low 12 bits of the linear address are the byte offset inside a 4 KB page and are never translated. Ten index bits per level give up to 2^20 pages, which covers a 4 GB linear space.

A requester presents an address, an access kind (read or write) and a privilege level (user or supervisor), and the walker answers with a physical address or a fault code. Entries are fetched through a simple read port. The walker raises a request and holds its address until the memory returns an acknowledge with the data word.

Every 32-bit entry uses this layout:

| Bits | Meaning |
|------|---------|
| [0] | present |
| [1] | writes allowed |
| [2] | user-level access allowed |
| [3] | modified |
| [31:12] | frame number |

The state machine has four states:

| State | Behaviour |
|-------|-----------|
| `ST_IDLE` | Waits for a request. |
| `ST_DIR` | Reads the directory entry. |
| `ST_TBL` | Reads the table entry. |
| `ST_DONE` | Presents the result for one cycle. |

It has these transitions:

- **accept**: `ST_IDLE` to `ST_DIR` when a request arrives.
- **dir_ok**: `ST_DIR` to `ST_TBL` when the acknowledged directory entry passes its checks.
- **dir_fault**: `ST_DIR` to `ST_DONE` when the directory entry fails a check.
- **tbl_end**: `ST_TBL` to `ST_DONE` on the table acknowledge, whatever the outcome.
- **retire**: `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `page_walker`

## Requirements
- R1: After reset, and after a reset applied in the middle of a walk, `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: The directory read address is the root frame shifted left by 12, plus linear bits [31:22] times 4. The low two address bits are 0, and the address stays stable while a read waits for its acknowledge.
- R3: The table read address is the directory entry's frame field [31:12] shifted left by 12, plus linear bits [21:12] times 4.
- R4: On success, `resp_fault` is 0 (none) and `resp_paddr` is the table entry's frame field concatenated with linear bits [11:0]. On any fault, `resp_paddr` is 0.
- R5: A directory entry with bit 0 clear ends the walk with `resp_fault` = 1 (not present), after exactly one memory read.
- R6: A table entry with bit 0 clear gives `resp_fault` = 1 after exactly two memory reads.
- R7: A write request to an entry with bit 1 clear gives `resp_fault` = 2 (access violation). The check applies at both levels, and a violation found in the directory entry ends the walk after one read.
- R8: A user request (`req_user` = 1) to an entry with bit 2 clear gives `resp_fault` = 2 at either level. A supervisor request ignores bit 2.
- R9: `done` is high for exactly one cycle per walk, and `req_ready` is high only when idle. A `req_valid` raised while busy is ignored: it produces no extra walk, no memory read and no extra `done`.
- R10: Entry bit 3 (modified) has no effect on the result.
- R11: The root frame is sampled when a request is accepted. Changing `root_frame` during a walk does not change that walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the top-level directory |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when the walker accepts a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user level, 0 = supervisor |
| mem_req | output | 1 | Entry read request, held until acknowledged |
| mem_addr | output | 32 | Physical byte address of the entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 2 | 0 none, 1 not present, 2 access violation |
| resp_paddr | output | 32 | Translated physical address (0 on fault) |

## Verification
The bench builds the walker with its default geometry: 32-bit addresses, 10-bit indexes and a 12-bit offset. At this size the real bit fields are exercised, including all-ones indexes and offsets at the top of the linear space.

The bench's memory model has a configurable acknowledge latency. It is run both with the fastest response and with a multi-cycle wait. The slow setting brings address holding under back-pressure within reach, along with busy-time requests, root changes and resets that land while a read is still outstanding.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_RIGHTS = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIR  = 2'd1,
        ST_TBL  = 2'd2,
        ST_DONE = 2'd3
    } walk_st_e;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;

endpackage

// File: rtl/walk_entry_addr.sv
module walk_entry_addr #(
    parameter int FRAME_W = 20,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 10
) (
    input  logic [FRAME_W-1:0]       frame,
    input  logic [IDX_W-1:0]         idx,
    output logic [FRAME_W+OFF_W-1:0] addr
);
    localparam int PAD_W = OFF_W - IDX_W - 2;

    // A table fits in one frame, so the scaled index is placed under the frame number.
    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = {frame, {PAD_W{1'b0}}, idx, 2'b00};
        end else begin : g_nopad
            assign addr = {frame, idx, 2'b00};
        end
    endgenerate

endmodule

// File: rtl/walk_entry_check.sv
module walk_entry_check
    import walk_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    output fault_e           fault
);
    always_comb begin
        if (!entry[BIT_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if (is_write && !entry[BIT_WRITE]) begin
            fault = FLT_RIGHTS;
        end else if (is_user && !entry[BIT_USER]) begin
            fault = FLT_RIGHTS;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/page_walker.sv
module page_walker
    import walk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [VA_W-OFF_W-1:0]   root_frame,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic                    req_write,
    input  logic                    req_user,
    output logic                    mem_req,
    output logic [VA_W-1:0]         mem_addr,
    input  logic                    mem_ack,
    input  logic [VA_W-1:0]         mem_rdata,
    output logic                    done,
    output logic [1:0]              resp_fault,
    output logic [VA_W-1:0]         resp_paddr
);
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int DIR_LO  = OFF_W + IDX_W;
    localparam int TBL_LO  = OFF_W;

    walk_st_e state, state_nx;

    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic               usr_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    fault_e             fault_q;
    logic [VA_W-1:0]    pa_q;

    logic [FRAME_W-1:0] cur_frame;
    logic [IDX_W-1:0]   cur_idx;
    fault_e             ent_fault;
    logic               accept;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign cur_frame = (state == ST_DIR) ? root_q : tbl_frame_q;
    assign cur_idx   = (state == ST_DIR) ? va_q[DIR_LO +: IDX_W] : va_q[TBL_LO +: IDX_W];

    walk_entry_addr #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W),
        .IDX_W   (IDX_W)
    ) u_addr (
        .frame (cur_frame),
        .idx   (cur_idx),
        .addr  (mem_addr)
    );

    walk_entry_check #(
        .ENT_W (VA_W)
    ) u_check (
        .entry    (mem_rdata),
        .is_write (wr_q),
        .is_user  (usr_q),
        .fault    (ent_fault)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_DIR;
            ST_DIR:  if (mem_ack)   state_nx = (ent_fault == FLT_NONE) ? ST_TBL : ST_DONE;
            ST_TBL:  if (mem_ack)   state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // captured request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            root_q      <= '0;
            tbl_frame_q <= '0;
            fault_q     <= FLT_NONE;
            pa_q        <= '0;
        end else begin
            if (accept) begin
                va_q    <= req_vaddr;
                wr_q    <= req_write;
                usr_q   <= req_user;
                root_q  <= root_frame;
                fault_q <= FLT_NONE;
                pa_q    <= '0;
            end
            if (state == ST_DIR && mem_ack) begin
                tbl_frame_q <= mem_rdata[VA_W-1:OFF_W];
                fault_q     <= ent_fault;
            end
            if (state == ST_TBL && mem_ack) begin
                fault_q <= ent_fault;
                pa_q    <= (ent_fault == FLT_NONE) ?
                           {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        mem_req    = (state == ST_DIR) || (state == ST_TBL);
        done       = (state == ST_DONE);
        resp_fault = fault_q;
        resp_paddr = pa_q;
    end

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R5
    absent_dir_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIR && mem_ack && !mem_rdata[BIT_PRESENT]) |=> (done && !mem_req));

    // R4
    offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_fault == FLT_NONE) |-> (resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

    // R4
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_fault != FLT_NONE) |-> (resp_paddr == '0));

endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [31:0] dent;
        logic [31:0] tent;
        logic [1:0]  efault;
        logic [31:0] epa;
        logic [1:0]  ereads;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 1'b0, 1'b0, 32'h00200007, 32'h0ABCD007, 2'd0, 32'h0ABCD678, 2'd2}, // R4 R3 supervisor read
        '{32'hFFFFF123, 1'b1, 1'b1, 32'h00300007, 32'h12345007, 2'd0, 32'h12345123, 2'd2}, // R4 user write at top indexes
        '{32'h00400000, 1'b0, 1'b0, 32'h00200006, 32'h0, 2'd1, 32'h0, 2'd1},               // R5 dir absent
        '{32'h80001FFF, 1'b0, 1'b0, 32'h00200007, 32'h11111006, 2'd1, 32'h0, 2'd2},        // R6 table absent
        '{32'h00801004, 1'b1, 1'b0, 32'h00200007, 32'h22222005, 2'd2, 32'h0, 2'd2},        // R7 read-only table
        '{32'h00801004, 1'b1, 1'b0, 32'h00200005, 32'h22222007, 2'd2, 32'h0, 2'd1},        // R7 read-only dir
        '{32'h00C00000, 1'b0, 1'b1, 32'h00200003, 32'h33333007, 2'd2, 32'h0, 2'd1},        // R8 user vs supervisor dir
        '{32'h00C00000, 1'b0, 1'b1, 32'h00200007, 32'h33333003, 2'd2, 32'h0, 2'd2},        // R8 user vs supervisor table
        '{32'h00000ABC, 1'b0, 1'b0, 32'h00200001, 32'h44444001, 2'd0, 32'h44444ABC, 2'd2}, // R8 supervisor ignores user bit
        '{32'h00C03010, 1'b0, 1'b1, 32'h0020000F, 32'h5555500F, 2'd0, 32'h55555010, 2'd2}  // R10 modified bit set
    };

    localparam logic [19:0] ROOT = 20'h00100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_frame = ROOT;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  resp_fault;
    logic [31:0] resp_paddr;

    int checks = 0;
    int errors = 0;
    int reads = 0;
    int bad_addr = 0;
    int lat = 0;
    int wait_cnt = 0;
    int cycles = 0;
    logic [31:0] cur_va, cur_dent, cur_tent;

    always #4 clk = ~clk;

    page_walker dut (
        .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        logic [31:0] da, ta;
        da = {ROOT, 12'h000} + {20'h0, cur_va[31:22], 2'b00};
        ta = {cur_dent[31:12], 12'h000} + {20'h0, cur_va[21:12], 2'b00};
        if (a == da) return cur_dent;
        if (a == ta) return cur_tent;
        bad_addr++;
        return 32'h0;
    endfunction

    // memory model: acknowledge after lat extra cycles
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (!rst_n) begin
            wait_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= lookup(mem_addr);
                reads     <= reads + 1;
                wait_cnt  <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_walk(input vec_t v, input bit swap_root, input bit busy_poke);
        int n;
        @(negedge clk);
        reads = 0; bad_addr = 0;
        cur_va = v.va; cur_dent = v.dent; cur_tent = v.tent;
        req_vaddr = v.va; req_write = v.wr; req_user = v.usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (swap_root) root_frame = 20'hFFFFF;
        if (busy_poke) begin
            chk(req_ready == 1'b0, "R9 ready low while busy", 32'(req_ready), 32'h0);
            req_vaddr = 32'hDEAD0000; req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done seen", 32'(done), 32'h1);
        chk(resp_fault == v.efault, "R4-R8 fault code", 32'(resp_fault), 32'(v.efault));
        chk(resp_paddr == v.epa, "R4 physical address", resp_paddr, v.epa);
        chk(reads == int'(v.ereads), "R5 R6 R7 read count", 32'(reads), 32'(v.ereads));
        chk(bad_addr == 0, "R2 R3 entry addresses", 32'(bad_addr), 32'h0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'h0);
        root_frame = ROOT;
        if (busy_poke) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done || mem_req) chk(1'b0, "R9 busy request ignored", {30'h0, done, mem_req}, 32'h0);
            end
            chk(reads == int'(v.ereads), "R9 no extra reads", 32'(reads), 32'(v.ereads));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'h1);
        chk(done == 1'b0 && mem_req == 1'b0, "R1 outputs in reset", {30'h0, done, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !mem_req && !done, "R1 idle after reset", {29'h0, req_ready, done, mem_req}, 32'h4);

        lat = 0;
        for (int i = 0; i < NV; i++) do_walk(VECS[i], 1'b0, 1'b0);
        lat = 3;
        for (int i = 0; i < NV; i += 3) do_walk(VECS[i], 1'b0, 1'b0);

        // R11 root change mid-walk
        do_walk(VECS[1], 1'b1, 1'b0);
        // R9 request while busy
        do_walk(VECS[0], 1'b0, 1'b1);

        // R1 reset in the middle of a walk
        @(negedge clk);
        cur_va = VECS[0].va; cur_dent = VECS[0].dent; cur_tent = VECS[0].tent;
        req_vaddr = VECS[0].va; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req && !done, "R1 idle after mid-walk reset", {29'h0, req_ready, done, mem_req}, 32'h4);

        // R2 directory address at index 0 with fast memory after reset
        lat = 0;
        do_walk(VECS[8], 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule